// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by reading a two-level page table that sits in memory. A client presents a virtual address with an access kind (load, store or instruction fetch). The walker reads the first-level entry, follows it to a second-level table, reads the leaf entry, and then returns either a physical address with its attribute bits or a fault code that says which check failed. The whole traversal runs in hardware. Software sees only real faults.

Only one walk is in flight at a time. The walker takes a new request only in its idle state. The table root comes from a register input, which is sampled when a request is accepted. Memory is reached through a simple read port: the walker holds a request with an address until it is granted, then waits for a data-valid strobe carrying a 32-bit word.

The control is a six-state machine:
- IDLE accepts a request and moves to L1_REQ.
- L1_REQ waits for grant and moves to L1_WAIT.
- L1_WAIT takes the first-level word. It moves to DONE on a fault, otherwise to L2_REQ.
- L2_REQ waits for grant and moves to L2_WAIT.
- L2_WAIT takes the leaf word and moves to DONE.
- DONE presents the response for one cycle and returns to IDLE.

Top module: `ptw_walker`

## Requirements
- R1: The virtual address splits into a first-level index in bits 31..22, a second-level index in bits 21..12 and a 12-bit offset. A successful response carries the physical page number from leaf bits 31..12, joined to the untranslated offset.
- R2: The first memory read of a walk uses the address root + first-level index × 4. The root is the value of `root_i` sampled in the accept cycle.
- R3: The second read uses the address (first-level entry bits 31..12 shifted left by 12) + second-level index × 4.
- R4: Entry bit 0 is the valid bit, and hit or miss depends on this bit alone. If it is clear, the walk ends with fault 1 at the first level or fault 3 at the second level. A first-level fault issues no second read. Validity is checked before any other bit.
- R5: Entry bit 1 marks a page resident in primary memory. A valid entry with this bit clear ends the walk with fault 2 at the first level or fault 4 at the second level.
- R6: Leaf bit 2 is read-only and leaf bit 3 is execute-disable. The access kind is coded 00 load, 01 store, 10 fetch; 11 is treated as a load. A store to a read-only page gives fault 5. A fetch from an execute-disabled page gives fault 6. Any other access translates and reports both bits.
- R7: Leaf bit 4 is the cacheable attribute and is reported with a successful translation.
- R8: `req_ready_o` is high only in IDLE and is high after reset. It stays low from the cycle after acceptance through the response cycle, so only one request is taken at a time.
- R9: `mem_req_o` stays high with a stable `mem_addr_o` until `mem_gnt_i` is seen. Read data is taken only in a cycle where `mem_rvalid_i` is high, after any number of wait cycles.
- R10: `rsp_valid_o` is a single-cycle pulse for each walk. A faulted response has the physical address and all attribute outputs at zero. Fault 0 means success.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| root_i | input | 32 | Physical address of the first-level table |
| req_valid_i | input | 1 | Translation request present |
| req_ready_o | output | 1 | Walker idle and able to accept |
| req_vaddr_i | input | 32 | Virtual address to translate |
| req_kind_i | input | 2 | Access kind: 00 load, 01 store, 10 fetch |
| mem_req_o | output | 1 | Memory read requested |
| mem_addr_o | output | 32 | Word address of the table entry |
| mem_gnt_i | input | 1 | Memory accepts the read this cycle |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 32 | Table entry read back |
| rsp_valid_o | output | 1 | Response pulse |
| rsp_paddr_o | output | 32 | Physical address (zero on fault) |
| rsp_ro_o | output | 1 | Page is read-only |
| rsp_xd_o | output | 1 | Page is execute-disabled |
| rsp_cache_o | output | 1 | Page is cacheable |
| rsp_fault_o | output | 3 | Fault code, 0 for success |

## Verification
The walker is exercised with three kinds of input pattern.
- Clean walks use different first- and second-level indices. These show whether the index fields and the offset are placed correctly.
- A walk with all-ones index and offset fields, and a walk under a changed root, catch truncated index arithmetic and a stale root.
- One entry per fault case drives a separate fault code and the short first-level-only read sequence. The same read-only and execute-disabled leaves are also reached with other access kinds, which separates a correct protection decision from one that ignores the access kind.

Each pattern runs with immediate grant and zero latency, and again with grant stalls and read latency. The repeat shows whether the walker honours the handshake rather than depending on fixed timing.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    typedef enum logic [2:0] {
        IDLE    = 3'd0,
        L1_REQ  = 3'd1,
        L1_WAIT = 3'd2,
        L2_REQ  = 3'd3,
        L2_WAIT = 3'd4,
        DONE    = 3'd5
    } walk_state_e;

    typedef enum logic [2:0] {
        FLT_NONE       = 3'd0,
        FLT_L1_INVALID = 3'd1,
        FLT_L1_ABSENT  = 3'd2,
        FLT_L2_INVALID = 3'd3,
        FLT_L2_ABSENT  = 3'd4,
        FLT_WRITE_RO   = 3'd5,
        FLT_FETCH_XD   = 3'd6
    } walk_fault_e;

    localparam logic [1:0] KIND_LOAD  = 2'b00;
    localparam logic [1:0] KIND_STORE = 2'b01;
    localparam logic [1:0] KIND_FETCH = 2'b10;

    // entry attribute bit positions
    localparam int unsigned ENT_VALID = 0;
    localparam int unsigned ENT_RESID = 1;
    localparam int unsigned ENT_RO    = 2;
    localparam int unsigned ENT_XD    = 3;
    localparam int unsigned ENT_CACHE = 4;
    localparam int unsigned ENT_ATTR_W = 5;

endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
    parameter int unsigned PA_W  = 32,
    parameter int unsigned IDX_W = 10,
    parameter int unsigned OFF_W = 12
) (
    input  logic [PA_W-1:0]       root_i,
    input  logic [IDX_W-1:0]      top_idx_i,
    input  logic [PA_W-OFF_W-1:0] leaf_base_i,
    input  logic [IDX_W-1:0]      leaf_idx_i,
    output logic [PA_W-1:0]       top_addr_o,
    output logic [PA_W-1:0]       leaf_addr_o
);
    localparam int unsigned PAD_W = PA_W - IDX_W - 2;

    logic [PA_W-1:0] top_ofs;
    logic [PA_W-1:0] leaf_ofs;
    logic [PA_W-1:0] leaf_table;

    always_comb begin
        top_ofs     = {{PAD_W{1'b0}}, top_idx_i, 2'b00};
        leaf_ofs    = {{PAD_W{1'b0}}, leaf_idx_i, 2'b00};
        leaf_table  = {leaf_base_i, {OFF_W{1'b0}}};
        top_addr_o  = root_i + top_ofs;
        leaf_addr_o = leaf_table + leaf_ofs;
    end
endmodule

// File: rtl/ptw_entry_check.sv
module ptw_entry_check
    import ptw_pkg::*;
#(
    parameter bit IS_LEAF = 1'b0
) (
    input  logic [ENT_ATTR_W-1:0] attr_i,
    input  logic [1:0]            kind_i,
    output walk_fault_e           fault_o
);
    walk_fault_e code_invalid;
    walk_fault_e code_absent;

    generate
        if (IS_LEAF) begin : g_leaf_codes
            assign code_invalid = FLT_L2_INVALID;
            assign code_absent  = FLT_L2_ABSENT;
        end else begin : g_top_codes
            assign code_invalid = FLT_L1_INVALID;
            assign code_absent  = FLT_L1_ABSENT;
        end
    endgenerate

    always_comb begin
        fault_o = FLT_NONE;
        if (!attr_i[ENT_VALID]) begin
            fault_o = code_invalid;
        end else if (!attr_i[ENT_RESID]) begin
            fault_o = code_absent;
        end else if (IS_LEAF && kind_i == KIND_STORE && attr_i[ENT_RO]) begin
            fault_o = FLT_WRITE_RO;
        end else if (IS_LEAF && kind_i == KIND_FETCH && attr_i[ENT_XD]) begin
            fault_o = FLT_FETCH_XD;
        end
    end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
    import ptw_pkg::*;
#(
    parameter int unsigned VA_W  = 32,
    parameter int unsigned PA_W  = 32,
    parameter int unsigned IDX_W = 10,
    parameter int unsigned OFF_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PA_W-1:0]  root_i,
    input  logic             req_valid_i,
    output logic             req_ready_o,
    input  logic [VA_W-1:0]  req_vaddr_i,
    input  logic [1:0]       req_kind_i,
    output logic             mem_req_o,
    output logic [PA_W-1:0]  mem_addr_o,
    input  logic             mem_gnt_i,
    input  logic             mem_rvalid_i,
    input  logic [31:0]      mem_rdata_i,
    output logic             rsp_valid_o,
    output logic [PA_W-1:0]  rsp_paddr_o,
    output logic             rsp_ro_o,
    output logic             rsp_xd_o,
    output logic             rsp_cache_o,
    output logic [2:0]       rsp_fault_o
);
    localparam int unsigned PPN_W   = PA_W - OFF_W;
    localparam int unsigned N_LEVEL = 2;

    walk_state_e state_q, state_d;

    logic [VA_W-1:0]   vaddr_q;
    logic [1:0]        kind_q;
    logic [PA_W-1:0]   root_q;
    logic [PPN_W-1:0]  base_q;
    logic [PA_W-1:0]   paddr_q;
    logic              ro_q, xd_q, cache_q;
    walk_fault_e       fault_q;

    logic [PA_W-1:0]   top_addr, leaf_addr;
    walk_fault_e       lvl_fault [N_LEVEL];
    logic              accept;
    logic [PPN_W-1:0]  ent_ppn;
    logic [ENT_ATTR_W-1:0] ent_attr;
    logic              unused_ent_bits;

    assign accept   = (state_q == IDLE) && req_valid_i;
    assign ent_ppn  = mem_rdata_i[31 -: PPN_W];
    assign ent_attr = mem_rdata_i[ENT_ATTR_W-1:0];
    assign unused_ent_bits = ^mem_rdata_i[OFF_W-1:ENT_ATTR_W];

    ptw_addr_gen #(
        .PA_W  (PA_W),
        .IDX_W (IDX_W),
        .OFF_W (OFF_W)
    ) u_addr (
        .root_i      (root_q),
        .top_idx_i   (vaddr_q[VA_W-1 -: IDX_W]),
        .leaf_base_i (base_q),
        .leaf_idx_i  (vaddr_q[OFF_W +: IDX_W]),
        .top_addr_o  (top_addr),
        .leaf_addr_o (leaf_addr)
    );

    generate
        for (genvar lv = 0; lv < N_LEVEL; lv++) begin : g_level
            ptw_entry_check #(
                .IS_LEAF (lv == N_LEVEL - 1)
            ) u_chk (
                .attr_i  (ent_attr),
                .kind_i  (kind_q),
                .fault_o (lvl_fault[lv])
            );
        end
    endgenerate

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IDLE:    if (req_valid_i) state_d = L1_REQ;
            L1_REQ:  if (mem_gnt_i) state_d = L1_WAIT;
            L1_WAIT: if (mem_rvalid_i) begin
                         state_d = (lvl_fault[0] != FLT_NONE) ? DONE : L2_REQ;
                     end
            L2_REQ:  if (mem_gnt_i) state_d = L2_WAIT;
            L2_WAIT: if (mem_rvalid_i) state_d = DONE;
            DONE:    state_d = IDLE;
            default: state_d = IDLE;
        endcase
    end

    // outputs
    always_comb begin
        req_ready_o = 1'b0;
        mem_req_o   = 1'b0;
        mem_addr_o  = '0;
        rsp_valid_o = 1'b0;
        unique case (state_q)
            IDLE:    req_ready_o = 1'b1;
            L1_REQ:  begin mem_req_o = 1'b1; mem_addr_o = top_addr;  end
            L2_REQ:  begin mem_req_o = 1'b1; mem_addr_o = leaf_addr; end
            DONE:    rsp_valid_o = 1'b1;
            default: ;
        endcase
        rsp_paddr_o = paddr_q;
        rsp_ro_o    = ro_q;
        rsp_xd_o    = xd_q;
        rsp_cache_o = cache_q;
        rsp_fault_o = fault_q;
    end

    // walk datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vaddr_q <= '0;
            kind_q  <= KIND_LOAD;
            root_q  <= '0;
            base_q  <= '0;
            paddr_q <= '0;
            ro_q    <= 1'b0;
            xd_q    <= 1'b0;
            cache_q <= 1'b0;
            fault_q <= FLT_NONE;
        end else begin
            if (accept) begin
                vaddr_q <= req_vaddr_i;
                kind_q  <= req_kind_i;
                root_q  <= root_i;
            end
            if (state_q == L1_WAIT && mem_rvalid_i) begin
                base_q <= ent_ppn;
                if (lvl_fault[0] != FLT_NONE) begin
                    fault_q <= lvl_fault[0];
                    paddr_q <= '0;
                    ro_q    <= 1'b0;
                    xd_q    <= 1'b0;
                    cache_q <= 1'b0;
                end
            end
            if (state_q == L2_WAIT && mem_rvalid_i) begin
                fault_q <= lvl_fault[N_LEVEL-1];
                if (lvl_fault[N_LEVEL-1] != FLT_NONE) begin
                    paddr_q <= '0;
                    ro_q    <= 1'b0;
                    xd_q    <= 1'b0;
                    cache_q <= 1'b0;
                end else begin
                    paddr_q <= {ent_ppn, vaddr_q[OFF_W-1:0]};
                    ro_q    <= ent_attr[ENT_RO];
                    xd_q    <= ent_attr[ENT_XD];
                    cache_q <= ent_attr[ENT_CACHE];
                end
            end
        end
    end
endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk #(
    parameter int unsigned VA_W  = 32,
    parameter int unsigned PA_W  = 32,
    parameter int unsigned IDX_W = 10,
    parameter int unsigned OFF_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic [PA_W-1:0]  root_i,
    input logic             req_valid_i,
    input logic             req_ready_o,
    input logic [VA_W-1:0]  req_vaddr_i,
    input logic [1:0]       req_kind_i,
    input logic             mem_req_o,
    input logic [PA_W-1:0]  mem_addr_o,
    input logic             mem_gnt_i,
    input logic             mem_rvalid_i,
    input logic [31:0]      mem_rdata_i,
    input logic             rsp_valid_o,
    input logic [PA_W-1:0]  rsp_paddr_o,
    input logic             rsp_ro_o,
    input logic             rsp_xd_o,
    input logic             rsp_cache_o,
    input logic [2:0]       rsp_fault_o
);
    logic [PA_W-1:0] c_root;
    logic [VA_W-1:0] c_vaddr;
    logic [1:0]      c_kind;
    logic            c_first;
    logic [PA_W-1:0] c_top_addr;
    logic            unused_chk;

    assign c_top_addr = c_root + {{(PA_W-IDX_W-2){1'b0}}, c_vaddr[VA_W-1 -: IDX_W], 2'b00};
    assign unused_chk = ^{mem_rvalid_i, mem_rdata_i};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_root  <= '0;
            c_vaddr <= '0;
            c_kind  <= '0;
            c_first <= 1'b0;
        end else begin
            if (req_valid_i && req_ready_o) begin
                c_root  <= root_i;
                c_vaddr <= req_vaddr_i;
                c_kind  <= req_kind_i;
                c_first <= 1'b1;
            end else if (mem_req_o && mem_gnt_i) begin
                c_first <= 1'b0;
            end
        end
    end

    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o |-> !req_ready_o);                                         // R8
    AST_RSP_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid_o |-> !req_ready_o);                                       // R8
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_gnt_i) |=> (mem_req_o && $stable(mem_addr_o)));  // R9
    AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid_o |=> !rsp_valid_o);                                       // R10
    AST_FAULT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid_o && rsp_fault_o != 3'd0) |->
        (rsp_paddr_o == '0 && !rsp_ro_o && !rsp_xd_o && !rsp_cache_o));      // R10
    AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid_o && rsp_fault_o == 3'd0) |->
        (rsp_paddr_o[OFF_W-1:0] == c_vaddr[OFF_W-1:0]));                     // R1
    AST_TOP_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (c_first && mem_req_o) |-> (mem_addr_o == c_top_addr));              // R2
    AST_STORE_NOT_RO: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid_o && rsp_fault_o == 3'd0 && c_kind == 2'b01) |-> !rsp_ro_o); // R6
endmodule

bind ptw_walker ptw_walker_chk #(
    .VA_W  (VA_W),
    .PA_W  (PA_W),
    .IDX_W (IDX_W),
    .OFF_W (OFF_W)
) u_walker_chk (.*);

// File: tb/sim_ptw_walker.sv
`timescale 1ns/1ps
module sim_ptw_walker;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] root_i = 32'h0001_0000;
    logic        req_valid_i = 1'b0;
    logic        req_ready_o;
    logic [31:0] req_vaddr_i = '0;
    logic [1:0]  req_kind_i = '0;
    logic        mem_req_o;
    logic [31:0] mem_addr_o;
    logic        mem_gnt_i = 1'b0;
    logic        mem_rvalid_i = 1'b0;
    logic [31:0] mem_rdata_i = '0;
    logic        rsp_valid_o;
    logic [31:0] rsp_paddr_o;
    logic        rsp_ro_o, rsp_xd_o, rsp_cache_o;
    logic [2:0]  rsp_fault_o;

    always #4 clk = ~clk;

    ptw_walker u0 (.*);

    typedef struct {
        logic [31:0] paddr;
        logic        ro, xd, cache;
        logic [2:0]  fault;
        string       tag;
    } exp_t;

    typedef struct {
        logic [31:0] addr;
        string       tag;
    } exp_addr_t;

    exp_t        exp_q[$];
    exp_addr_t   addr_q[$];
    logic [31:0] mem_m [logic [31:0]];

    int checks = 0;
    int errors = 0;
    int stall_len = 0;
    int lat = 0;
    bit busy = 1'b0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // memory model: grant after stall_len cycles, data after lat cycles
    int  wait_ctr = 0;
    int  lat_ctr = 0;
    bit  pend = 1'b0;
    logic [31:0] pend_addr;
    always @(negedge clk) begin
        mem_rvalid_i = 1'b0;
        mem_gnt_i    = 1'b0;
        if (rst_n) begin
            if (pend) begin
                if (lat_ctr == 0) begin
                    mem_rvalid_i = 1'b1;
                    mem_rdata_i  = mem_m.exists(pend_addr) ? mem_m[pend_addr] : 32'h0;
                    pend = 1'b0;
                end else begin
                    lat_ctr--;
                end
            end else if (mem_req_o) begin
                if (wait_ctr < stall_len) begin
                    wait_ctr++;
                end else begin
                    mem_gnt_i = 1'b1;
                    wait_ctr  = 0;
                    pend      = 1'b1;
                    lat_ctr   = lat;
                    pend_addr = mem_addr_o;
                    if (addr_q.size() == 0) begin
                        chk(1'b0, "R4 unexpected extra read", {32'h0, mem_addr_o}, 64'h0);
                    end else begin
                        exp_addr_t ea;
                        ea = addr_q.pop_front();
                        chk(mem_addr_o == ea.addr, ea.tag, {32'h0, mem_addr_o}, {32'h0, ea.addr});
                    end
                end
            end
        end
    end

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            if (busy) begin
                chk(!req_ready_o, "R8 ready low during walk", {63'h0, req_ready_o}, 64'h0);
            end
            if (rsp_valid_o) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R10 response without request", {61'h0, rsp_fault_o}, 64'h0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    chk(rsp_paddr_o == e.paddr && rsp_ro_o == e.ro && rsp_xd_o == e.xd &&
                        rsp_cache_o == e.cache && rsp_fault_o == e.fault, e.tag,
                        {rsp_paddr_o, 25'h0, rsp_ro_o, rsp_xd_o, rsp_cache_o, 1'b0, rsp_fault_o},
                        {e.paddr, 25'h0, e.ro, e.xd, e.cache, 1'b0, e.fault});
                    busy = 1'b0;
                end
            end
        end
    end

    task automatic push_addr(input logic [31:0] a, input string tag);
        exp_addr_t ea;
        ea.addr = a; ea.tag = tag;
        addr_q.push_back(ea);
    endtask

    task automatic issue(input logic [31:0] va, input logic [1:0] kind,
                         input logic [31:0] pa, input logic ro, input logic xd,
                         input logic cache, input logic [2:0] fault, input string tag);
        exp_t e;
        @(negedge clk);
        while (!req_ready_o) @(negedge clk);
        e.paddr = pa; e.ro = ro; e.xd = xd; e.cache = cache; e.fault = fault; e.tag = tag;
        exp_q.push_back(e);
        req_valid_i = 1'b1;
        req_vaddr_i = va;
        req_kind_i  = kind;
        @(negedge clk);
        req_valid_i = 1'b0;
        busy = 1'b1;
        while (exp_q.size() != 0) @(negedge clk);
    endtask

    task automatic run_set(input string pfx);
        // R1 R3 R7 clean load, cacheable
        push_addr(32'h0001_0004, {pfx, " R2 top addr"});
        push_addr(32'h0002_0008, {pfx, " R3 leaf addr"});
        issue(32'h0040_2345, 2'b00, 32'hABCD_E345, 0, 0, 1, 3'd0, {pfx, " R1 R7 clean load"});
        // R6 store to read-only
        push_addr(32'h0001_0004, {pfx, " R2 top addr"});
        push_addr(32'h0002_000C, {pfx, " R3 leaf addr"});
        issue(32'h0040_3010, 2'b01, 32'h0, 0, 0, 0, 3'd5, {pfx, " R6 store to read-only"});
        push_addr(32'h0001_0004, {pfx, " R2 top addr"});
        push_addr(32'h0002_000C, {pfx, " R3 leaf addr"});
        issue(32'h0040_3010, 2'b00, 32'h1234_5010, 1, 0, 0, 3'd0, {pfx, " R6 load from read-only"});
        // R6 fetch from execute-disabled
        push_addr(32'h0001_0004, {pfx, " R2 top addr"});
        push_addr(32'h0002_0010, {pfx, " R3 leaf addr"});
        issue(32'h0040_4ABC, 2'b10, 32'h0, 0, 0, 0, 3'd6, {pfx, " R6 fetch from exec-disabled"});
        push_addr(32'h0001_0004, {pfx, " R2 top addr"});
        push_addr(32'h0002_0010, {pfx, " R3 leaf addr"});
        issue(32'h0040_4ABC, 2'b01, 32'h5555_5ABC, 0, 1, 0, 3'd0, {pfx, " R6 store to exec-disabled"});
        push_addr(32'h0001_0004, {pfx, " R2 top addr"});
        push_addr(32'h0002_000C, {pfx, " R3 leaf addr"});
        issue(32'h0040_3010, 2'b11, 32'h1234_5010, 1, 0, 0, 3'd0, {pfx, " R6 kind 11 as load"});
        // R4 first-level invalid: one read only
        push_addr(32'h0001_0008, {pfx, " R4 top addr"});
        issue(32'h0080_0000, 2'b00, 32'h0, 0, 0, 0, 3'd1, {pfx, " R4 first-level invalid"});
        // R4 invalid wins over resident bit
        push_addr(32'h0001_0010, {pfx, " R4 top addr"});
        issue(32'h0100_0000, 2'b00, 32'h0, 0, 0, 0, 3'd1, {pfx, " R4 valid checked first"});
        // R5 first-level not resident
        push_addr(32'h0001_000C, {pfx, " R5 top addr"});
        issue(32'h00C0_0000, 2'b00, 32'h0, 0, 0, 0, 3'd2, {pfx, " R5 first-level absent"});
        // R4 second-level invalid
        push_addr(32'h0001_0004, {pfx, " R2 top addr"});
        push_addr(32'h0002_0014, {pfx, " R3 leaf addr"});
        issue(32'h0040_5000, 2'b00, 32'h0, 0, 0, 0, 3'd3, {pfx, " R4 second-level invalid"});
        // R5 second-level not resident
        push_addr(32'h0001_0004, {pfx, " R2 top addr"});
        push_addr(32'h0002_0018, {pfx, " R3 leaf addr"});
        issue(32'h0040_6000, 2'b00, 32'h0, 0, 0, 0, 3'd4, {pfx, " R5 second-level absent"});
        // R1 all-ones indices and offset
        push_addr(32'h0001_0FFC, {pfx, " R2 top addr max index"});
        push_addr(32'h0004_0FFC, {pfx, " R3 leaf addr max index"});
        issue(32'hFFFF_FFFF, 2'b10, 32'hFEDC_BFFF, 0, 0, 1, 3'd0, {pfx, " R1 all-ones address"});
    endtask

    initial begin
        // table contents (bit0 valid, bit1 resident, bit2 ro, bit3 xd, bit4 cacheable)
        mem_m[32'h0001_0004] = 32'h0002_0003;
        mem_m[32'h0001_0008] = 32'h0003_0000;
        mem_m[32'h0001_000C] = 32'h0003_0001;
        mem_m[32'h0001_0010] = 32'h0003_0002;
        mem_m[32'h0001_0FFC] = 32'h0004_0003;
        mem_m[32'h0002_0008] = 32'hABCD_E013;
        mem_m[32'h0002_000C] = 32'h1234_5007;
        mem_m[32'h0002_0010] = 32'h5555_500B;
        mem_m[32'h0002_0014] = 32'h0000_0000;
        mem_m[32'h0002_0018] = 32'h7777_7011;
        mem_m[32'h0004_0FFC] = 32'hFEDC_B013;
        mem_m[32'h0008_0004] = 32'h0005_0003;
        mem_m[32'h0005_0008] = 32'h0BEE_F003;

        repeat (4) @(negedge clk);
        chk(req_ready_o == 1'b1, "R8 ready after reset", {63'h0, req_ready_o}, 64'h1);
        chk(mem_req_o == 1'b0 && rsp_valid_o == 1'b0, "R10 quiet after reset",
            {62'h0, mem_req_o, rsp_valid_o}, 64'h0);
        rst_n = 1'b1;

        stall_len = 0; lat = 0;
        run_set("fast");
        stall_len = 2; lat = 3;
        run_set("slow R9");
        stall_len = 1; lat = 0;
        run_set("mixed R9");

        // R2 root sampled at acceptance, changed afterwards
        root_i = 32'h0008_0000;
        push_addr(32'h0008_0004, "R2 new root top addr");
        push_addr(32'h0005_0008, "R3 new root leaf addr");
        fork
            issue(32'h0040_2345, 2'b00, 32'h0BEE_F345, 0, 0, 0, 3'd0, "R2 walk under new root");
            begin
                repeat (3) @(negedge clk);
                root_i = 32'h0001_0000;
            end
        join

        repeat (5) @(negedge clk);
        chk(addr_q.size() == 0, "R4 all expected reads issued", {32'h0, addr_q.size()}, 64'h0);
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule